// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous static memory with a flow-through read path and a built-in four-beat burst address sequencer. The default word is 18 bits wide. It is split into two 9-bit byte lanes, and each lane stores 8 data bits plus a parity bit. An access opens when one of two address strobes is sampled low at a rising clock edge. After that, an advance input steps the low two address bits through the burst in either linear or interleaved order. Holding the advance input high suspends the burst at its current address.

Reads are flow-through. The word at the address registered at an edge appears on the read data output during the same cycle, with no output pipeline register. Writes take the data present at the clock edge. A global write control writes every lane. A separate byte-write control writes only the lanes that are individually selected. The bidirectional data bus is modelled as a data input, a data output and a drive-enable flag. A sleep input stops all accesses and keeps the bus undriven.

Top module: `sync_burst_sram`

## Requirements
- R1: Each word holds two 9-bit lanes. Lane k occupies bits [9k+8:9k], and bit 9k+8 is that lane's parity bit. All nine bits of a lane, parity included, are stored and returned unchanged.
- R2: Reads are flow-through. After an edge that starts or continues a read, `dq_o` carries the stored word for the current address before the next edge. `dq_oe` is 1 during that cycle when `out_en_n` is 0. Reset clears the drive state.
- R3: With `order_il`=0, beat k of a burst that starts at address B uses low bits (B[1:0]+k) mod 4. The upper address bits stay at B's value.
- R4: With `order_il`=1, beat k uses low bits B[1:0] XOR k.
- R5: At an edge with no strobe and `adv_n`=1, an open burst keeps its current address.
- R6: The fifth beat of a burst returns to the starting address B.
- R7: `ctl_strobe_n`=0 in the middle of a burst loads `addr_i` and restarts the burst at beat 0.
- R8: When both strobes are low, `cpu_strobe_n` takes precedence. A cycle opened by `cpu_strobe_n` is always a read, even when write controls are active. Write data is accepted on the continuation cycles that follow.
- R9: `all_wr_n`=0 writes both lanes, whatever the values of `lane_wr_n` and `lane_sel_n`.
- R10: With `all_wr_n`=1 and `lane_wr_n`=0, only the lanes whose `lane_sel_n` bit is 0 are written (bit k selects lane k). If no lane is selected, or `lane_wr_n`=1, the cycle is a read.
- R11: `out_en_n`=1 forces `dq_oe` to 0 without waiting for a clock edge.
- R12: After a write cycle, `dq_oe` stays 0 through suspended cycles. It returns to 1 only after a strobe or advance cycle that reads.
- R13: A strobe sampled while `chip_sel_n`=1 is a deselect. `dq_oe` goes to 0 and the open burst ends, so later advance cycles do not drive the bus.
- R14: While `sleep_i`=1, `dq_oe` is 0 and nothing is written. After sleep ends, the bus stays undriven until a new read is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| addr_i | input | ADDR_W | Word address, sampled when a strobe is low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, read-only start, highest priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| chip_sel_n | input | 1 | Chip select, active low, sampled with a strobe |
| all_wr_n | input | 1 | Global write, active low, writes every lane |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep request, active high |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_i | input | DATA_W | Write data, bus input side |
| dq_o | output | DATA_W | Read data, bus output side |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions check several properties on every cycle. An output enable held high keeps the bus undriven. A suspended burst holds its address. A linear step adds one to the low address bits, and the upper bits never change inside a burst. A processor-strobe cycle always leaves the core reading. Deselect, sleep and write cycles are each followed by an undriven bus. Other properties only the bench's scenarios can show: that written data, parity bits included, comes back from the right address in both burst orders; that the burst wraps; that lane masks merge partial writes correctly; and that writes attempted during sleep or on a processor-strobe cycle leave the array unchanged.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef logic [1:0] beat_t;

   // Low address bits for a given beat of a burst.
   function automatic beat_t beat_lo(beat_t start, beat_t beat, logic il);
      beat_lo = il ? (start ^ beat) : (start + beat);
   endfunction

endpackage

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
   parameter int LANES = 2
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_mask
);

   generate
      if (LANES < 1) begin : g_bad
         $error("sbs_lane_dec: LANES must be at least 1");
      end
   endgenerate

   always_comb begin
      if (!all_wr_n)
         lane_mask = '1;
      else if (!lane_wr_n)
         lane_mask = ~lane_sel_n;
      else
         lane_mask = '0;
   end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              stop,
   input  logic              il,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [ADDR_W-1:0] addr_cur,
   output logic              active
);

   generate
      if (ADDR_W < 3) begin : g_bad
         $error("sbs_burst_seq: ADDR_W must be at least 3");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q, base_n;
   beat_t             cnt_q, cnt_n;
   logic              act_q, act_n;

   always_comb begin
      base_n = base_q;
      cnt_n  = cnt_q;
      act_n  = act_q;
      if (stop) begin
         act_n = 1'b0;
      end else if (load) begin
         base_n = addr_i;
         cnt_n  = '0;
         act_n  = 1'b1;
      end else if (step && act_q) begin
         cnt_n = cnt_q + 2'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         base_q <= base_n;
         cnt_q  <= cnt_n;
         act_q  <= act_n;
      end
   end

   assign addr_nxt = {base_n[ADDR_W-1:2], beat_lo(base_n[1:0], cnt_n, il)};
   assign addr_cur = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_q, il)};
   assign active   = act_q;

   // R5: a suspended burst keeps its address
   a_r5_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !load && !step && !stop) |=> (!$stable(il) || $stable(addr_cur)));

   // R3: a linear step adds one to the low bits
   a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && step && !load && !stop && !il) |=>
         (il || addr_cur[1:0] == $past(addr_cur[1:0]) + 2'd1));

   // R3: upper address bits fixed inside a burst
   a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !load && !stop) |=> $stable(addr_cur[ADDR_W-1:2]));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LW     = 9
) (
   input  logic                clk,
   input  logic [LANES-1:0]    we,
   input  logic [ADDR_W-1:0]   waddr,
   input  logic [LANES*LW-1:0] wdata,
   input  logic [ADDR_W-1:0]   raddr,
   output logic [LANES*LW-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we[g])
               mem[waddr] <= wdata[g*LW +: LW];
         end
         assign rdata[g*LW +: LW] = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
   parameter int ADDR_W    = 8,
   parameter int LANES     = 2,
   parameter int LANE_DATA = 8,
   localparam int LW       = LANE_DATA + 1,
   localparam int DATA_W   = LANES * LW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cpu_strobe_n,
   input  logic              ctl_strobe_n,
   input  logic              adv_n,
   input  logic              chip_sel_n,
   input  logic              all_wr_n,
   input  logic              lane_wr_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              out_en_n,
   input  logic              sleep_i,
   input  logic              order_il,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);

   generate
      if (LANE_DATA < 1) begin : g_bad
         $error("sync_burst_sram: LANE_DATA must be at least 1");
      end
   endgenerate

   logic [LANES-1:0]  lane_mask;
   logic [LANES-1:0]  wr_lanes;
   logic [ADDR_W-1:0] addr_nxt, addr_cur;
   logic              active, reading_q;
   logic              strobe, go_load, go_desel, cont, step, wr_now;

   sbs_lane_dec #(.LANES(LANES)) u_dec (
      .all_wr_n  (all_wr_n),
      .lane_wr_n (lane_wr_n),
      .lane_sel_n(lane_sel_n),
      .lane_mask (lane_mask)
   );

   assign strobe   = !cpu_strobe_n || !ctl_strobe_n;
   assign go_load  = !sleep_i && strobe && !chip_sel_n;
   assign go_desel = !sleep_i && strobe && chip_sel_n;
   assign cont     = !sleep_i && !strobe && active;
   assign step     = cont && !adv_n;
   assign wr_now   = ((go_load && cpu_strobe_n) || cont) && (|lane_mask);
   assign wr_lanes = wr_now ? lane_mask : '0;

   sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go_load),
      .step    (step),
      .stop    (sleep_i || go_desel),
      .il      (order_il),
      .addr_i  (addr_i),
      .addr_nxt(addr_nxt),
      .addr_cur(addr_cur),
      .active  (active)
   );

   sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LW(LW)) u_mem (
      .clk  (clk),
      .we   (wr_lanes),
      .waddr(addr_nxt),
      .wdata(dq_i),
      .raddr(addr_cur),
      .rdata(dq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         reading_q <= 1'b0;
      else if (sleep_i || go_desel)
         reading_q <= 1'b0;
      else if (go_load)
         reading_q <= !wr_now;
      else if (cont)
         reading_q <= wr_now ? 1'b0 : (step ? 1'b1 : reading_q);
   end

   assign dq_oe = reading_q && !out_en_n && !sleep_i;

   // R11: output enable high keeps the bus quiet
   a_r11_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !dq_oe);

   // R8: processor strobe opens a read
   a_r8_cpu_is_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strobe_n && !chip_sel_n && !sleep_i) |=> reading_q);

   // R13: deselect leaves the bus undriven
   a_r13_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && chip_sel_n && !sleep_i) |=> !dq_oe);

   // R14: sleep leaves the bus undriven
   a_r14_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> !dq_oe);

   // R12: a write cycle is followed by an undriven bus
   a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_lanes) |=> !dq_oe);

   // R9: global write reaches every lane in the decoder output
   a_r9_global_all: assert property (@(posedge clk) disable iff (!rst_n)
      !all_wr_n |-> (&lane_mask));

endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;

   localparam int AW = 8;
   localparam int DW = 18;
   localparam int NV = 34;

   typedef struct packed {
      logic [3:0]    req;
      logic [10:0]   c;   // cpu ctl adv sel _ gw bwe _ ls[1:0] _ oe slp il
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          ed;
      logic [DW-1:0] eq;
   } vec_t;

   localparam vec_t VT [NV] = '{
      {4'd9,  11'b1010_01_11_000, 8'h10, 18'h3A5A5, 1'b0, 18'h0},     // R9 write 10
      {4'd3,  11'b1100_01_11_000, 8'h00, 18'h00111, 1'b0, 18'h0},     // R3 write 11
      {4'd3,  11'b1100_01_11_000, 8'h00, 18'h00222, 1'b0, 18'h0},     // R3 write 12
      {4'd3,  11'b1100_01_11_000, 8'h00, 18'h00333, 1'b0, 18'h0},     // R3 write 13
      {4'd6,  11'b1100_01_11_000, 8'h00, 18'h0ABCD, 1'b0, 18'h0},     // R6 wrap to 10
      {4'd8,  11'b0110_01_11_000, 8'h10, 18'h3FFFF, 1'b1, 18'h0ABCD}, // R8 read only
      {4'd3,  11'b1100_11_11_000, 8'h00, 18'h0,     1'b1, 18'h00111}, // R3
      {4'd5,  11'b1110_11_11_000, 8'h00, 18'h0,     1'b1, 18'h00111}, // R5 suspend
      {4'd3,  11'b1100_11_11_000, 8'h00, 18'h0,     1'b1, 18'h00222}, // R3
      {4'd3,  11'b1100_11_11_000, 8'h00, 18'h0,     1'b1, 18'h00333}, // R3
      {4'd6,  11'b1100_11_11_000, 8'h00, 18'h0,     1'b1, 18'h0ABCD}, // R6 wrap
      {4'd7,  11'b1010_11_11_001, 8'h11, 18'h0,     1'b1, 18'h00111}, // R7 reload
      {4'd4,  11'b1100_11_11_001, 8'h00, 18'h0,     1'b1, 18'h0ABCD}, // R4 11^1
      {4'd4,  11'b1100_11_11_001, 8'h00, 18'h0,     1'b1, 18'h00333}, // R4 11^2
      {4'd4,  11'b1100_11_11_001, 8'h00, 18'h0,     1'b1, 18'h00222}, // R4 11^3
      {4'd9,  11'b1010_01_11_000, 8'h20, 18'h00000, 1'b0, 18'h0},     // R9 clear 20
      {4'd10, 11'b1010_10_10_000, 8'h20, 18'h3FFFF, 1'b0, 18'h0},     // R10 lane 0
      {4'd10, 11'b1010_10_01_000, 8'h20, 18'h2AAAA, 1'b0, 18'h0},     // R10 lane 1
      {4'd10, 11'b1010_10_11_000, 8'h20, 18'h0,     1'b1, 18'h2ABFF}, // R10 no lane
      {4'd9,  11'b1010_01_11_000, 8'h21, 18'h13579, 1'b0, 18'h0},     // R9 gw no sel
      {4'd1,  11'b1010_11_11_000, 8'h21, 18'h0,     1'b1, 18'h13579}, // R1
      {4'd11, 11'b1010_11_11_100, 8'h21, 18'h0,     1'b0, 18'h0},     // R11 oe high
      {4'd2,  11'b1110_11_11_000, 8'h00, 18'h0,     1'b1, 18'h13579}, // R2
      {4'd12, 11'b1010_01_11_000, 8'h30, 18'h02468, 1'b0, 18'h0},     // R12 write
      {4'd12, 11'b1110_11_11_000, 8'h00, 18'h0,     1'b0, 18'h0},     // R12 suspend
      {4'd12, 11'b0110_11_11_000, 8'h30, 18'h0,     1'b1, 18'h02468}, // R12 read
      {4'd13, 11'b1011_11_11_000, 8'h10, 18'h0,     1'b0, 18'h0},     // R13 deselect
      {4'd13, 11'b1100_11_11_000, 8'h00, 18'h0,     1'b0, 18'h0},     // R13 adv
      {4'd2,  11'b0110_11_11_000, 8'h10, 18'h0,     1'b1, 18'h0ABCD}, // R2
      {4'd14, 11'b0111_11_11_000, 8'h10, 18'h0,     1'b0, 18'h0},     // R14 desel
      {4'd14, 11'b1110_11_11_010, 8'h00, 18'h0,     1'b0, 18'h0},     // R14 sleep
      {4'd14, 11'b1010_01_11_010, 8'h10, 18'h00000, 1'b0, 18'h0},     // R14 no write
      {4'd14, 11'b1110_11_11_000, 8'h00, 18'h0,     1'b0, 18'h0},     // R14 woken
      {4'd14, 11'b0110_11_11_000, 8'h10, 18'h0,     1'b1, 18'h0ABCD}  // R14 kept
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_i;
   logic          cpu_strobe_n, ctl_strobe_n, adv_n, chip_sel_n;
   logic          all_wr_n, lane_wr_n, out_en_n, sleep_i, order_il;
   logic [1:0]    lane_sel_n;
   logic [DW-1:0] dq_i, dq_o;
   logic          dq_oe;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   sync_burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_DATA(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
      .adv_n(adv_n), .chip_sel_n(chip_sel_n), .all_wr_n(all_wr_n),
      .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
      .out_en_n(out_en_n), .sleep_i(sleep_i), .order_il(order_il),
      .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got,
                      input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic set_idle();
      {cpu_strobe_n, ctl_strobe_n, adv_n, chip_sel_n} = 4'b1110;
      {all_wr_n, lane_wr_n, lane_sel_n} = 4'b1111;
      {out_en_n, sleep_i, order_il} = 3'b000;
      addr_i = '0;
      dq_i   = '0;
   endtask

   initial begin
      rst_n = 1'b0;
      set_idle();
      repeat (3) @(posedge clk);
      #1;
      chk("R2 reset drive", {17'd0, dq_oe}, 18'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {cpu_strobe_n, ctl_strobe_n, adv_n, chip_sel_n, all_wr_n, lane_wr_n,
          lane_sel_n, out_en_n, sleep_i, order_il} = VT[i].c;
         addr_i = VT[i].a;
         dq_i   = VT[i].d;
         @(posedge clk);
         #1;
         chk($sformatf("R%0d step %0d drive", VT[i].req, i),
             {17'd0, dq_oe}, {17'd0, VT[i].ed});
         if (VT[i].ed)
            chk($sformatf("R%0d step %0d data", VT[i].req, i), dq_o, VT[i].eq);
      end

      // R11: output enable acts without a clock edge
      @(negedge clk);
      set_idle();
      out_en_n = 1'b1;
      #1;
      chk("R11 async oe off", {17'd0, dq_oe}, 18'd0);
      out_en_n = 1'b0;
      #1;
      chk("R11 async oe on", {17'd0, dq_oe}, 18'd1);
      chk("R2 data held", dq_o, 18'h0ABCD);

      // R2: reset in the middle of a read clears the drive
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R2 reset mid read", {17'd0, dq_oe}, 18'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog got=hang exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule